// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept. Its input is the 48-bit destination address, delivered serially at the start of each frame. It compares that address with a station address held in host-writable registers, and it also recognises the all-ones broadcast destination. A mode word changes the outcome: it can accept every frame, refuse broadcasts, or ignore a station-address hit. A separate accept input lets an outside filter force acceptance. The block reports a decision and a match type once the last address bit has been seen.

The host reaches the configuration through a small word-addressed port. Words 0, 1 and 2 hold station address bits 15:0, 31:16 and 47:32. Word 3 is the mode word. Writes only take effect while the controller reports itself halted, that is stopped or suspended. Reads work at any time. A frame begins with a one-cycle start strobe. The address bits follow on later cycles, each qualified by a bit-valid strobe, lowest-numbered bit first.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: Register word 0 holds station address bits 15:0, word 1 bits 31:16, word 2 bits 47:32, and word 3 the mode word. `reg_rdata` shows the addressed word combinationally at any time.
- R2: Serial address bit k is compared with station address bit k, and bit 0 arrives first. A bit-reversed station address is not a physical match.
- R3: A register write takes effect only while `halted` is 1. A write while `halted` is 0 leaves every word unchanged.
- R4: When mode bit 15 (promiscuous) is 1, every frame is accepted with match type 11.
- R5: An all-ones destination is accepted with match type 10 when mode bit 14 is 0. When mode bit 14 is 1, that frame is rejected unless another rule accepts it.
- R6: A destination equal to the station address is accepted with match type 01 when mode bit 13 is 0. When mode bit 13 is 1, that hit is ignored.
- R7: When `ext_accept` is 1 in the cycle the address completes, the frame is accepted with match type 11.
- R8: Reset clears the mode word to zero and clears `dec_valid`, `accept` and `match_type`.
- R9: Until each of the three station words has been written since reset, no physical match is reported.
- R10: `dec_valid`, `accept` and `match_type` update on the clock edge after the one that samples the 48th bit. They then hold until the next start strobe, which clears `dec_valid` on the following edge.
- R11: A start strobe partway through an address discards the partial comparison and restarts at bit 0.
- R12: The match type is 00 none, 01 physical, 10 broadcast, 11 promiscuous or external. `accept` is 1 exactly when the match type is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halted | input | 1 | Controller stopped or suspended; enables register writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| sof | input | 1 | Start-of-frame strobe |
| bit_vld | input | 1 | Address bit valid |
| bit_in | input | 1 | Serial address bit |
| ext_accept | input | 1 | Force acceptance from an outside filter |
| dec_valid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |
| match_type | output | 2 | Kind of match that accepted the frame |

## Verification
Register reads are combinational, so each read is sampled shortly after the address is set. A write is read back on the falling edge that follows its rising edge. The decision passes through two registers: the serial comparator finishes on the edge that samples the 48th bit, and the decision register loads on the next edge. The bench therefore confirms that `dec_valid` is still 0 one falling edge after the last bit, and reads the result one falling edge later. The sweep covers every combination of the three mode bits, three kinds of destination and both levels of `ext_accept`. Each expected type is computed from the precedence rules. Separate checks cover the hold period and the clear that a start strobe causes one edge later.

// File: rtl/eth_af_pkg.sv
package eth_af_pkg;
   typedef enum logic [1:0] {
      MT_NONE   = 2'b00,
      MT_PHYS   = 2'b01,
      MT_BCAST  = 2'b10,
      MT_FORCED = 2'b11
   } match_t;

   localparam int MODE_PROM_BIT  = 15;
   localparam int MODE_NOBC_BIT  = 14;
   localparam int MODE_NOPHY_BIT = 13;
endpackage

// File: rtl/af_regs.sv
module af_regs #(
   parameter int WORD_W = 16,
   parameter int NWORDS = 3,
   parameter int RA_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     halted,
   input  logic                     wr,
   input  logic [RA_W-1:0]          addr,
   input  logic [WORD_W-1:0]        wdata,
   output logic [WORD_W-1:0]        rdata,
   output logic [WORD_W*NWORDS-1:0] sta,
   output logic                     sta_known,
   output logic [WORD_W-1:0]        mode
);
   logic [WORD_W-1:0] sta_w [NWORDS];
   logic [NWORDS-1:0] written;
   logic              wr_ok;

   assign wr_ok = wr && halted;

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_ok && addr == RA_W'(g))
            sta_w[g] <= wdata;
      end
      always_ff @(posedge clk) begin
         if (rst)                              written[g] <= 1'b0;
         else if (wr_ok && addr == RA_W'(g))  written[g] <= 1'b1;
      end
      assign sta[g*WORD_W +: WORD_W] = sta_w[g];
   end

   always_ff @(posedge clk) begin
      if (rst)                                  mode <= '0;
      else if (wr_ok && addr == RA_W'(NWORDS))  mode <= wdata;
   end

   assign sta_known = &written;

   always_comb begin
      rdata = '0;
      if (addr == RA_W'(NWORDS)) rdata = mode;
      for (int i = 0; i < NWORDS; i++)
         if (addr == RA_W'(i)) rdata = sta_w[i];
   end

   AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
      (wr && !halted) |=> ($stable(mode) && $stable(written))) else $error("gated write"); // R3
   AST_MODE_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (mode == '0 && written == '0)) else $error("mode reset"); // R8
endmodule

// File: rtl/af_serial.sv
module af_serial #(
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sof,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic [ADDR_W-1:0] sta,
   output logic              done,
   output logic              phys_eq,
   output logic              all_ones
);
   logic [CNT_W-1:0] cnt;
   logic             active;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         active   <= 1'b0;
         phys_eq  <= 1'b0;
         all_ones <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (sof) begin
            cnt      <= '0;
            active   <= 1'b1;
            phys_eq  <= 1'b1;
            all_ones <= 1'b1;
         end else if (active && bit_vld) begin
            phys_eq  <= phys_eq & (bit_in == sta[cnt]);
            all_ones <= all_ones & bit_in;
            cnt      <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_W-1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(ADDR_W)) else $error("count overflow"); // R11
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done twice"); // R10
endmodule

// File: rtl/af_decide.sv
module af_decide
   import eth_af_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       sof,
   input  logic       done,
   input  logic       phys_eq,
   input  logic       all_ones,
   input  logic       sta_known,
   input  logic       prom,
   input  logic       no_bc,
   input  logic       no_phys,
   input  logic       ext_acc,
   output logic       dec_valid,
   output logic       accept,
   output logic [1:0] match_type
);
   match_t nxt;

   always_comb begin
      if (prom || ext_acc)                     nxt = MT_FORCED;
      else if (phys_eq && sta_known && !no_phys) nxt = MT_PHYS;
      else if (all_ones && !no_bc)             nxt = MT_BCAST;
      else                                     nxt = MT_NONE;
   end

   always_ff @(posedge clk) begin
      if (rst || sof) begin
         dec_valid  <= 1'b0;
         accept     <= 1'b0;
         match_type <= MT_NONE;
      end else if (done) begin
         dec_valid  <= 1'b1;
         accept     <= (nxt != MT_NONE);
         match_type <= nxt;
      end
   end

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && !sof && !done) |=> (dec_valid && $stable(accept) && $stable(match_type)))
      else $error("decision moved"); // R10
   AST_SOF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      sof |=> !dec_valid) else $error("sof clear"); // R11
   AST_PROM: assert property (@(posedge clk) disable iff (rst)
      (done && prom && !sof) |=> (accept && match_type == MT_FORCED)) else $error("prom"); // R4
   AST_NO_PHYS: assert property (@(posedge clk) disable iff (rst)
      (done && no_phys) |=> (match_type != MT_PHYS)) else $error("phys disabled"); // R6
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import eth_af_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NWORDS = 3
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              halted,
   input  logic                              reg_wr,
   input  logic [$clog2(NWORDS+1)-1:0]       reg_addr,
   input  logic [WORD_W-1:0]                 reg_wdata,
   output logic [WORD_W-1:0]                 reg_rdata,
   input  logic                              sof,
   input  logic                              bit_vld,
   input  logic                              bit_in,
   input  logic                              ext_accept,
   output logic                              dec_valid,
   output logic                              accept,
   output logic [1:0]                        match_type
);
   localparam int ADDR_W = WORD_W * NWORDS;
   localparam int RA_W   = $clog2(NWORDS+1);
   localparam int CNT_W  = $clog2(ADDR_W+1);

   if (WORD_W < MODE_PROM_BIT + 1) begin : g_bad_word
      $error("WORD_W must hold the mode bits");
   end
   if (NWORDS < 1) begin : g_bad_nwords
      $error("NWORDS must be at least 1");
   end

   logic [ADDR_W-1:0] sta;
   logic              sta_known;
   logic [WORD_W-1:0] mode;
   logic              done, phys_eq, all_ones;

   af_regs #(.WORD_W(WORD_W), .NWORDS(NWORDS), .RA_W(RA_W)) u_regs (
      .clk(clk), .rst(rst), .halted(halted), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sta(sta), .sta_known(sta_known),
      .mode(mode)
   );

   af_serial #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_serial (
      .clk(clk), .rst(rst), .sof(sof), .bit_vld(bit_vld), .bit_in(bit_in),
      .sta(sta), .done(done), .phys_eq(phys_eq), .all_ones(all_ones)
   );

   af_decide u_decide (
      .clk(clk), .rst(rst), .sof(sof), .done(done), .phys_eq(phys_eq),
      .all_ones(all_ones), .sta_known(sta_known),
      .prom(mode[MODE_PROM_BIT]), .no_bc(mode[MODE_NOBC_BIT]),
      .no_phys(mode[MODE_NOPHY_BIT]), .ext_acc(ext_accept),
      .dec_valid(dec_valid), .accept(accept), .match_type(match_type)
   );

   AST_ACCEPT_ENC: assert property (@(posedge clk) disable iff (rst)
      accept == (match_type != 2'b00)) else $error("accept encoding"); // R12
endmodule

// File: tb/tb_eth_rx_addr_filter.sv
module tb_eth_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        halted = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sof = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, ext_accept = 1'b0;
   logic        dec_valid, accept;
   logic [1:0]  match_type;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [47:0] STA   = 48'h0A1B2C3D4E5F;
   localparam logic [47:0] OTHER = 48'h123456789ABC;

   always #2 clk = ~clk;

   eth_rx_addr_filter dut (
      .clk(clk), .rst(rst), .halted(halted), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof(sof), .bit_vld(bit_vld),
      .bit_in(bit_in), .ext_accept(ext_accept), .dec_valid(dec_valid),
      .accept(accept), .match_type(match_type)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic send_bits(input logic [47:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         bit_vld = 1'b1; bit_in = a[i];
         @(negedge clk);
      end
      bit_vld = 1'b0;
   endtask

   // Frame: start strobe, 48 bits, then check the R10 timing and read the result.
   task automatic frame(input logic [47:0] a, input logic ext, output logic [1:0] mt,
                        output logic acc);
      @(negedge clk);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      ext_accept = ext;
      send_bits(a, 48);
      check(dec_valid == 1'b0, "R10 early", dec_valid, 0);
      @(negedge clk);
      check(dec_valid == 1'b1, "R10 valid", dec_valid, 1);
      mt = match_type; acc = accept;
      ext_accept = 1'b0;
   endtask

   function automatic logic [1:0] expect_mt(bit prom, bit nobc, bit nophy, bit known,
                                            int kind, bit ext);
      if (prom || ext) return 2'b11;
      if (kind == 0 && known && !nophy) return 2'b01;
      if (kind == 1 && !nobc) return 2'b10;
      return 2'b00;
   endfunction

   initial begin
      repeat (1000) @(posedge clk);
      repeat (99000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic [1:0]  mt;
      logic        acc;
      logic [47:0] rev;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      rd_reg(2'd3, rd);
      check(rd == 16'h0, "R8 mode", rd, 0);
      check(dec_valid == 0 && accept == 0 && match_type == 0, "R8 outputs",
            {dec_valid, accept, match_type}, 0);

      // R9: only two words written, the address equal to them plus a zero top word
      wr_reg(2'd0, STA[15:0]);
      wr_reg(2'd1, STA[31:16]);
      frame({16'h0000, STA[31:0]}, 1'b0, mt, acc);
      check(mt == 2'b00, "R9 unwritten", mt, 0);
      wr_reg(2'd2, STA[47:32]);

      // R1 readback of every word
      rd_reg(2'd0, rd); check(rd == STA[15:0],  "R1 word0", rd, STA[15:0]);
      rd_reg(2'd1, rd); check(rd == STA[31:16], "R1 word1", rd, STA[31:16]);
      rd_reg(2'd2, rd); check(rd == STA[47:32], "R1 word2", rd, STA[47:32]);

      // R3 writes ignored while running
      halted = 1'b0;
      wr_reg(2'd0, 16'hFFFF);
      wr_reg(2'd3, 16'h8000);
      rd_reg(2'd0, rd); check(rd == STA[15:0], "R3 word0", rd, STA[15:0]);
      rd_reg(2'd3, rd); check(rd == 16'h0, "R3 mode", rd, 0);
      frame(OTHER, 1'b0, mt, acc);
      check(mt == 2'b00, "R3 mode unchanged", mt, 0);

      // R2 bit order
      for (int i = 0; i < 48; i++) rev[i] = STA[47-i];
      frame(rev, 1'b0, mt, acc);
      check(mt == 2'b00, "R2 reversed", mt, 0);

      // R11 restart mid address
      @(negedge clk);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      send_bits(OTHER, 20);
      frame(STA, 1'b0, mt, acc);
      check(mt == 2'b01, "R11 restart", mt, 1);

      // R10 hold then clear
      repeat (5) @(negedge clk);
      check(dec_valid && match_type == 2'b01, "R10 hold", match_type, 1);
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
      check(dec_valid == 1'b0, "R10 clear", dec_valid, 0);

      // Sweep R4 R5 R6 R7 R12
      for (int m = 0; m < 8; m++) begin
         halted = 1'b1;
         wr_reg(2'd3, {m[2:0], 13'h0});
         halted = 1'b0;
         for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < 2; e++) begin
               logic [1:0] ex;
               ex = expect_mt(m[2], m[1], m[0], 1'b1, k, e[0]);
               frame(k == 0 ? STA : (k == 1 ? 48'hFFFFFFFFFFFF : OTHER), e[0], mt, acc);
               if (m[2]) check(mt == ex, "R4 prom", mt, ex);
               else if (e[0]) check(mt == ex, "R7 ext", mt, ex);
               else if (k == 0) check(mt == ex, "R6 phys", mt, ex);
               else check(mt == ex, "R5 bcast", mt, ex);
               check(acc == (ex != 2'b00), "R12 accept", acc, ex != 2'b00);
            end
         end
      end

      summary();
      $finish;
   end
endmodule